// File: doc/BRIEF.md
# Memory Dependence Learning and Prediction Tables

This block learns at run time which loads take their value from a recent store, and predicts that relation for later dynamic instances of the same instructions. A direct-mapped detection table remembers, per word address, which store PC last wrote it. A store that rewrites a live entry for the same address reports the earlier store PC as output-dependent. A committing load that hits in the table has found a true dependence on the recorded store.

Every detected dependence trains two PC-keyed prediction tables, one for loads and one for stores. Each entry holds a status counter and a dependence tag. The tag is shared by every dependence that touches the same load or store, so it can serve as the synonym both instructions derive at decode. A decode-time lookup returns a registered "dependent" flag and the tag. Verification outcomes from later in the pipeline train the counters of the load and of the store.

Top module: `mdp_tables`

## Requirements
- R1: After a synchronous reset every output is 0, both prediction tables are empty, and the detection table holds no valid entry.
- R2: A committing store writes its PC and word address into the detection slot chosen by the low address bits. If that slot already held a valid entry for the same word address, the next cycle shows `od_valid`=1 with the earlier store PC on `od_pc`. A different address sharing the slot gives no report.
- R3: A committing load whose word address matches a valid detection entry shows `det_valid`=1 and that store PC on `det_st_pc` in the next cycle. A store committed in the same cycle is not yet visible to the load.
- R4: A detection that finds neither instruction in its prediction table takes a fresh tag from a counter. The counter starts at 0 after reset, advances by one per fresh tag, and wraps. Both new entries get that tag, and it appears on `det_tag`.
- R5: If the load already has an entry, its tag is reused for both instructions. Otherwise, if the store has an entry, the store's tag is reused.
- R6: The load counter is a 2-bit saturating counter that predicts dependent when its value is 1 or more. A new entry starts at 1. A detection or a verify with `vf_ok`=1 increments it, and a verify with `vf_ok`=0 decrements it.
- R7: The store counter is one bit that predicts dependent when set. It is set by a detection or a verify with `vf_ok`=1, and cleared by a verify with `vf_ok`=0.
- R8: A verify names a load PC and a store PC. A PC that has no entry is not allocated, so a later lookup of it still misses. A verify in a cycle that carries a detection is dropped.
- R9: Each prediction table replaces the least recently trained entry when it has no free entry; the lowest-index free entry is used first. Lookups do not count as use.
- R10: A lookup (`lk_is_load` selects the table) answers one cycle later with `lk_rsp_valid`=1. On a hit `lk_tag` carries the entry's tag and `lk_dep` its prediction. On a miss both are 0, and both are 0 when no lookup was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store commit |
| st_pc | input | PC_W | PC of committing store |
| st_addr | input | WADDR_W | Word address of committing store |
| ld_valid | input | 1 | Load commit (detection probe) |
| ld_pc | input | PC_W | PC of committing load |
| ld_addr | input | WADDR_W | Word address of committing load |
| vf_valid | input | 1 | Verification outcome present |
| vf_ld_pc | input | PC_W | Load PC of verified forward |
| vf_st_pc | input | PC_W | Store PC of verified forward |
| vf_ok | input | 1 | 1 = forwarded value was correct |
| lk_valid | input | 1 | Decode lookup request |
| lk_is_load | input | 1 | 1 = look up load table, 0 = store table |
| lk_pc | input | PC_W | PC being decoded |
| od_valid | output | 1 | Output dependence found by store |
| od_pc | output | PC_W | Earlier store PC that was overwritten |
| det_valid | output | 1 | True dependence detected by load |
| det_st_pc | output | PC_W | Store PC the load depends on |
| det_tag | output | TAG_W | Tag given to the dependence |
| lk_rsp_valid | output | 1 | Lookup answer valid |
| lk_dep | output | 1 | Predicted dependent |
| lk_tag | output | TAG_W | Dependence tag (synonym) |

## Verification
The bench goes after slot aliasing in the detection table. A design that compares only the slot index would report false output dependences and false detections. It forces a load and a store to the same address in one cycle, where forwarding the new store PC would break R3. It walks the counters to both saturation limits, where wrap-around would flip a "never dependent" prediction back to dependent. It overfills the small tables, where an eviction that counts lookups as use, or that picks the wrong victim, shows up as a lost or surviving tag. Tag merging is checked by chaining dependences that share a load or a store. A design that always took a fresh tag, or that preferred the store's tag, would split one synonym into two.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  // Control of one training write into a prediction table.
  typedef struct packed {
    logic en;      // a write is requested
    logic alloc;   // take a victim entry on a miss
    logic up;      // 1 = count up, 0 = count down
    logic tag_wr;  // overwrite the entry's tag
  } upd_ctl_t;

  localparam upd_ctl_t UPD_NONE = '{en: 1'b0, alloc: 1'b0, up: 1'b0, tag_wr: 1'b0};
endpackage

// File: rtl/mdp_det_table.sv
module mdp_det_table #(
  parameter int DT_ENTRIES = 256,
  parameter int WADDR_W    = 30,
  parameter int PC_W       = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               st_valid,
  input  logic [PC_W-1:0]    st_pc,
  input  logic [WADDR_W-1:0] st_addr,
  input  logic               ld_valid,
  input  logic [WADDR_W-1:0] ld_addr,
  output logic               ld_hit,
  output logic [PC_W-1:0]    ld_spc,
  output logic               od_hit,
  output logic [PC_W-1:0]    od_spc
);
  localparam int IDX_W = $clog2(DT_ENTRIES);
  localparam int KEY_W = WADDR_W - IDX_W;

  logic              v_q   [DT_ENTRIES];
  logic [KEY_W-1:0]  key_q [DT_ENTRIES];
  logic [PC_W-1:0]   pc_q  [DT_ENTRIES];

  logic [IDX_W-1:0] s_idx, l_idx;
  logic [KEY_W-1:0] s_key, l_key;

  assign s_idx = st_addr[IDX_W-1:0];
  assign s_key = st_addr[WADDR_W-1:IDX_W];
  assign l_idx = ld_addr[IDX_W-1:0];
  assign l_key = ld_addr[WADDR_W-1:IDX_W];

  // Reads see the contents before this cycle's store.
  assign ld_hit = ld_valid && v_q[l_idx] && (key_q[l_idx] == l_key);
  assign ld_spc = pc_q[l_idx];
  assign od_hit = st_valid && v_q[s_idx] && (key_q[s_idx] == s_key);
  assign od_spc = pc_q[s_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DT_ENTRIES; i++) v_q[i] <= 1'b0;
    end else if (st_valid) begin
      v_q[s_idx] <= 1'b1;
    end
  end

  // Payload without reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (st_valid) begin
      key_q[s_idx] <= s_key;
      pc_q[s_idx]  <= st_pc;
    end
  end
endmodule

// File: rtl/mdp_pred_table.sv
module mdp_pred_table
  import mdp_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PC_W    = 32,
  parameter int TAG_W   = 8,
  parameter int CTR_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  q_pc,
  output logic             q_hit,
  output logic [CTR_W-1:0] q_ctr,
  output logic [TAG_W-1:0] q_tag,
  input  logic [PC_W-1:0]  a_pc,
  output logic             a_hit,
  output logic [TAG_W-1:0] a_tag,
  input  upd_ctl_t         u_ctl,
  input  logic [PC_W-1:0]  u_pc,
  input  logic [TAG_W-1:0] u_tag
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CTR_W-1:0] CMAX = '1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic              v_q    [ENTRIES];
  logic [PC_W-1:0]   pc_q   [ENTRIES];
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [CTR_W-1:0]  ctr_q  [ENTRIES];
  logic [IDX_W-1:0]  rank_q [ENTRIES];  // 0 = most recently trained

  logic [IDX_W-1:0] q_idx, a_idx, u_idx, vic_idx, w_idx;
  logic             u_hit, have_free, do_wr;
  logic [CTR_W-1:0] base, ctr_nx;

  always_comb begin
    q_hit = 1'b0; q_idx = '0;
    a_hit = 1'b0; a_idx = '0;
    u_hit = 1'b0; u_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v_q[i] && pc_q[i] == q_pc) begin q_hit = 1'b1; q_idx = IDX_W'(i); end
      if (v_q[i] && pc_q[i] == a_pc) begin a_hit = 1'b1; a_idx = IDX_W'(i); end
      if (v_q[i] && pc_q[i] == u_pc) begin u_hit = 1'b1; u_idx = IDX_W'(i); end
    end
  end

  assign q_ctr = ctr_q[q_idx];
  assign q_tag = tag_q[q_idx];
  assign a_tag = tag_q[a_idx];

  // Victim: lowest free entry, else the least recently trained one.
  always_comb begin
    have_free = 1'b0;
    vic_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!v_q[i]) begin have_free = 1'b1; vic_idx = IDX_W'(i); end
    end
    if (!have_free) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rank_q[i] == OLDEST) vic_idx = IDX_W'(i);
      end
    end
  end

  assign do_wr = u_ctl.en && (u_hit || u_ctl.alloc);
  assign w_idx = u_hit ? u_idx : vic_idx;
  assign base  = u_hit ? ctr_q[u_idx] : '0;

  always_comb begin
    if (u_ctl.up) ctr_nx = (base == CMAX) ? base : base + 1'b1;
    else          ctr_nx = (base == '0)   ? base : base - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        v_q[i]    <= 1'b0;
        pc_q[i]   <= '0;
        tag_q[i]  <= '0;
        ctr_q[i]  <= '0;
        rank_q[i] <= IDX_W'(i);
      end
    end else if (do_wr) begin
      v_q[w_idx]   <= 1'b1;
      pc_q[w_idx]  <= u_pc;
      ctr_q[w_idx] <= ctr_nx;
      if (u_ctl.tag_wr) tag_q[w_idx] <= u_tag;
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == w_idx)              rank_q[i] <= '0;
        else if (rank_q[i] < rank_q[w_idx])  rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdp_tables.sv
module mdp_tables
  import mdp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int WADDR_W    = 30,
  parameter int TAG_W      = 8,
  parameter int DT_ENTRIES = 256,
  parameter int PT_ENTRIES = 32,
  parameter int LD_CTR_W   = 2,
  parameter int ST_CTR_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               st_valid,
  input  logic [PC_W-1:0]    st_pc,
  input  logic [WADDR_W-1:0] st_addr,
  input  logic               ld_valid,
  input  logic [PC_W-1:0]    ld_pc,
  input  logic [WADDR_W-1:0] ld_addr,
  input  logic               vf_valid,
  input  logic [PC_W-1:0]    vf_ld_pc,
  input  logic [PC_W-1:0]    vf_st_pc,
  input  logic               vf_ok,
  input  logic               lk_valid,
  input  logic               lk_is_load,
  input  logic [PC_W-1:0]    lk_pc,
  output logic               od_valid,
  output logic [PC_W-1:0]    od_pc,
  output logic               det_valid,
  output logic [PC_W-1:0]    det_st_pc,
  output logic [TAG_W-1:0]   det_tag,
  output logic               lk_rsp_valid,
  output logic               lk_dep,
  output logic [TAG_W-1:0]   lk_tag
);
  logic             dt_hit, od_hit;
  logic [PC_W-1:0]  dt_spc, od_spc;

  mdp_det_table #(
    .DT_ENTRIES(DT_ENTRIES), .WADDR_W(WADDR_W), .PC_W(PC_W)
  ) u_det (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_pc(st_pc), .st_addr(st_addr),
    .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_hit(dt_hit), .ld_spc(dt_spc),
    .od_hit(od_hit), .od_spc(od_spc)
  );

  logic             lq_hit, sq_hit, la_hit, sa_hit;
  logic [LD_CTR_W-1:0] lq_ctr;
  logic [ST_CTR_W-1:0] sq_ctr;
  logic [TAG_W-1:0] lq_tag, sq_tag, la_tag, sa_tag;
  logic [TAG_W-1:0] tag_q, tag_sel;
  logic             fresh;
  upd_ctl_t         ctl;
  logic [PC_W-1:0]  lu_pc, su_pc;

  // Load entry's tag first, then the store's, else a new one.
  assign fresh   = dt_hit && !la_hit && !sa_hit;
  assign tag_sel = la_hit ? la_tag : (sa_hit ? sa_tag : tag_q);

  always_comb begin
    if (dt_hit) begin
      ctl   = '{en: 1'b1, alloc: 1'b1, up: 1'b1, tag_wr: 1'b1};
      lu_pc = ld_pc;
      su_pc = dt_spc;
    end else if (vf_valid) begin
      ctl   = '{en: 1'b1, alloc: 1'b0, up: vf_ok, tag_wr: 1'b0};
      lu_pc = vf_ld_pc;
      su_pc = vf_st_pc;
    end else begin
      ctl   = UPD_NONE;
      lu_pc = vf_ld_pc;
      su_pc = vf_st_pc;
    end
  end

  mdp_pred_table #(
    .ENTRIES(PT_ENTRIES), .PC_W(PC_W), .TAG_W(TAG_W), .CTR_W(LD_CTR_W)
  ) u_ld_tab (
    .clk(clk), .rst(rst),
    .q_pc(lk_pc), .q_hit(lq_hit), .q_ctr(lq_ctr), .q_tag(lq_tag),
    .a_pc(ld_pc), .a_hit(la_hit), .a_tag(la_tag),
    .u_ctl(ctl), .u_pc(lu_pc), .u_tag(tag_sel)
  );

  mdp_pred_table #(
    .ENTRIES(PT_ENTRIES), .PC_W(PC_W), .TAG_W(TAG_W), .CTR_W(ST_CTR_W)
  ) u_st_tab (
    .clk(clk), .rst(rst),
    .q_pc(lk_pc), .q_hit(sq_hit), .q_ctr(sq_ctr), .q_tag(sq_tag),
    .a_pc(dt_spc), .a_hit(sa_hit), .a_tag(sa_tag),
    .u_ctl(ctl), .u_pc(su_pc), .u_tag(tag_sel)
  );

  logic             sel_hit, sel_dep;
  logic [TAG_W-1:0] sel_tag;

  assign sel_hit = lk_is_load ? lq_hit : sq_hit;
  assign sel_dep = lk_is_load ? (lq_ctr != '0) : (sq_ctr != '0);
  assign sel_tag = lk_is_load ? lq_tag : sq_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q        <= '0;
      od_valid     <= 1'b0;
      od_pc        <= '0;
      det_valid    <= 1'b0;
      det_st_pc    <= '0;
      det_tag      <= '0;
      lk_rsp_valid <= 1'b0;
      lk_dep       <= 1'b0;
      lk_tag       <= '0;
    end else begin
      if (fresh) tag_q <= tag_q + 1'b1;
      od_valid     <= od_hit;
      od_pc        <= od_hit ? od_spc : '0;
      det_valid    <= dt_hit;
      det_st_pc    <= dt_hit ? dt_spc : '0;
      det_tag      <= dt_hit ? tag_sel : '0;
      lk_rsp_valid <= lk_valid;
      lk_dep       <= lk_valid && sel_hit && sel_dep;
      lk_tag       <= (lk_valid && sel_hit) ? sel_tag : '0;
    end
  end
endmodule

// File: rtl/mdp_tables_chk.sv
module mdp_tables_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             st_valid,
  input logic             ld_valid,
  input logic             lk_valid,
  input logic             od_valid,
  input logic             det_valid,
  input logic             lk_rsp_valid,
  input logic             lk_dep,
  input logic [TAG_W-1:0] lk_tag,
  input logic [TAG_W-1:0] next_tag
);
  // R1
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!od_valid && !det_valid && !lk_rsp_valid && !lk_dep));

  // R2
  p_od_needs_store_r2: assert property (@(posedge clk) disable iff (rst)
    od_valid |-> $past(st_valid));

  // R3
  p_det_needs_load_r3: assert property (@(posedge clk) disable iff (rst)
    det_valid |-> $past(ld_valid));

  // R4
  p_tag_steps_by_one_r4: assert property (@(posedge clk) disable iff (rst)
    (next_tag != $past(next_tag)) |-> (next_tag == $past(next_tag) + 1'b1));

  // R10
  p_lookup_answers_r10: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> lk_rsp_valid);

  // R10
  p_idle_answer_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !lk_rsp_valid |-> (!lk_dep && lk_tag == '0));
endmodule

bind mdp_tables mdp_tables_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst),
  .st_valid(st_valid), .ld_valid(ld_valid), .lk_valid(lk_valid),
  .od_valid(od_valid), .det_valid(det_valid),
  .lk_rsp_valid(lk_rsp_valid), .lk_dep(lk_dep), .lk_tag(lk_tag),
  .next_tag(tag_q)
);

// File: tb/tb_mdp_tables.sv
module tb_mdp_tables;
  localparam int PC_W = 16, WA_W = 12, TAG_W = 3, DTN = 16, PTN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic st_valid = 0, ld_valid = 0, vf_valid = 0, vf_ok = 0, lk_valid = 0, lk_is_load = 0;
  logic [PC_W-1:0] st_pc = 0, ld_pc = 0, vf_ld_pc = 0, vf_st_pc = 0, lk_pc = 0;
  logic [WA_W-1:0] st_addr = 0, ld_addr = 0;
  logic od_valid, det_valid, lk_rsp_valid, lk_dep;
  logic [PC_W-1:0] od_pc, det_st_pc;
  logic [TAG_W-1:0] det_tag, lk_tag;

  mdp_tables #(.PC_W(PC_W), .WADDR_W(WA_W), .TAG_W(TAG_W), .DT_ENTRIES(DTN),
               .PT_ENTRIES(PTN), .LD_CTR_W(2), .ST_CTR_W(1)) dut (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_pc(st_pc), .st_addr(st_addr),
    .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_addr(ld_addr),
    .vf_valid(vf_valid), .vf_ld_pc(vf_ld_pc), .vf_st_pc(vf_st_pc), .vf_ok(vf_ok),
    .lk_valid(lk_valid), .lk_is_load(lk_is_load), .lk_pc(lk_pc),
    .od_valid(od_valid), .od_pc(od_pc),
    .det_valid(det_valid), .det_st_pc(det_st_pc), .det_tag(det_tag),
    .lk_rsp_valid(lk_rsp_valid), .lk_dep(lk_dep), .lk_tag(lk_tag)
  );

  // Reference model: [0] = store table, [1] = load table.
  bit              dv  [DTN];
  logic [WA_W-1:0] da  [DTN];
  logic [PC_W-1:0] dp  [DTN];
  bit              mv  [2][PTN];
  logic [PC_W-1:0] mpc [2][PTN];
  logic [TAG_W-1:0] mtag [2][PTN];
  int              mctr [2][PTN];
  int              mst  [2][PTN];
  int              now_t = 0;
  logic [TAG_W-1:0] ntag = '0;
  int n_cmp = 0, n_bad = 0;

  function automatic int find(int t, logic [PC_W-1:0] pc);
    for (int i = 0; i < PTN; i++) if (mv[t][i] && mpc[t][i] == pc) return i;
    return -1;
  endfunction

  function automatic int victim(int t);
    int best = 0;
    for (int i = 0; i < PTN; i++) if (!mv[t][i]) return i;
    for (int i = 1; i < PTN; i++) if (mst[t][i] < mst[t][best]) best = i;
    return best;
  endfunction

  task automatic mupd(int t, logic [PC_W-1:0] pc, bit alloc, bit up, bit tw, logic [TAG_W-1:0] tg);
    int i = find(t, pc);
    int cmax = (t == 1) ? 3 : 1;
    if (i < 0) begin
      if (!alloc) return;
      i = victim(t);
      mv[t][i] = 1; mpc[t][i] = pc; mctr[t][i] = 0;
    end
    if (up) begin if (mctr[t][i] < cmax) mctr[t][i]++; end
    else    begin if (mctr[t][i] > 0)    mctr[t][i]--; end
    if (tw) mtag[t][i] = tg;
    now_t++;
    mst[t][i] = now_t;
  endtask

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step();
    int si = int'(st_addr % DTN);
    int li = int'(ld_addr % DTN);
    bit e_od, e_det, e_dep;
    logic [PC_W-1:0] e_odpc, e_spc;
    logic [TAG_W-1:0] e_tag, e_ltag;
    int t, k, a, b;
    e_od = st_valid && dv[si] && da[si] == st_addr;
    e_odpc = dp[si];
    e_det = ld_valid && dv[li] && da[li] == ld_addr;
    e_spc = dp[li];
    t = lk_is_load ? 1 : 0;
    k = find(t, lk_pc);
    e_dep = lk_valid && k >= 0 && mctr[t][k] != 0;
    e_ltag = (lk_valid && k >= 0) ? mtag[t][k] : '0;
    e_tag = '0;
    if (e_det) begin
      a = find(1, ld_pc);
      b = find(0, e_spc);
      if (a >= 0) e_tag = mtag[1][a];
      else if (b >= 0) e_tag = mtag[0][b];
      else begin e_tag = ntag; ntag = ntag + 1'b1; end
      mupd(1, ld_pc, 1, 1, 1, e_tag);
      mupd(0, e_spc, 1, 1, 1, e_tag);
    end else if (vf_valid) begin
      mupd(1, vf_ld_pc, 0, vf_ok, 0, '0);
      mupd(0, vf_st_pc, 0, vf_ok, 0, '0);
    end
    if (st_valid) begin dv[si] = 1; da[si] = st_addr; dp[si] = st_pc; end
    @(posedge clk); #2;
    chk("R2 od_valid", 32'(od_valid), 32'(e_od));
    if (e_od) chk("R2 od_pc", 32'(od_pc), 32'(e_odpc));
    chk("R3 det_valid", 32'(det_valid), 32'(e_det));
    if (e_det) begin
      chk("R3 det_st_pc", 32'(det_st_pc), 32'(e_spc));
      chk("R4/R5 det_tag", 32'(det_tag), 32'(e_tag));
    end
    chk("R10 lk_rsp_valid", 32'(lk_rsp_valid), 32'(lk_valid));
    chk(lk_is_load ? "R6 lk_dep load" : "R7 lk_dep store", 32'(lk_dep), 32'(e_dep));
    chk("R10 lk_tag", 32'(lk_tag), 32'(e_ltag));
    st_valid = 0; ld_valid = 0; vf_valid = 0; lk_valid = 0;
  endtask

  task automatic st(logic [PC_W-1:0] pc, logic [WA_W-1:0] ad);
    st_valid = 1; st_pc = pc; st_addr = ad; step();
  endtask
  task automatic ld(logic [PC_W-1:0] pc, logic [WA_W-1:0] ad);
    ld_valid = 1; ld_pc = pc; ld_addr = ad; step();
  endtask
  task automatic vf(logic [PC_W-1:0] lp, logic [PC_W-1:0] sp, bit ok);
    vf_valid = 1; vf_ld_pc = lp; vf_st_pc = sp; vf_ok = ok; step();
  endtask
  task automatic lk(bit isl, logic [PC_W-1:0] pc);
    lk_valid = 1; lk_is_load = isl; lk_pc = pc; step();
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // R1: reset state at the ports, then empty tables
    chk("R1 od_valid", 32'(od_valid), 0);
    chk("R1 det_valid", 32'(det_valid), 0);
    chk("R1 lk_rsp_valid", 32'(lk_rsp_valid), 0);
    chk("R1 lk_tag", 32'(lk_tag), 0);
    lk(1, 16'h2000); lk(0, 16'h1000);
    // R2: same address rewrite, then slot alias (5 and 21 share slot 5)
    st(16'h1000, 12'd5); st(16'h1004, 12'd5); st(16'h1008, 12'd21); st(16'h100c, 12'd5);
    // R3/R4: detection with fresh tag, both table entries get it
    ld(16'h2000, 12'd5); lk(1, 16'h2000); lk(0, 16'h100c);
    ld(16'h2004, 12'd5);                 // R5: store's tag reused
    st(16'h1010, 12'd7); ld(16'h2000, 12'd7);  // R5: load's tag reused
    lk(0, 16'h1010);
    // R6: saturate up, then walk down to 0 and below
    vf(16'h2000, 16'h100c, 1); vf(16'h2000, 16'h100c, 1); lk(1, 16'h2000);
    repeat (5) vf(16'h2000, 16'h100c, 0);
    lk(1, 16'h2000); lk(0, 16'h100c);    // R7: store bit cleared
    // R8: verify for unknown PCs allocates nothing
    vf(16'h2f00, 16'h1f00, 1); lk(1, 16'h2f00); lk(0, 16'h1f00);
    // R8: verify dropped in a detection cycle
    ld_valid = 1; ld_pc = 16'h2004; ld_addr = 12'd5;
    vf_valid = 1; vf_ld_pc = 16'h2000; vf_st_pc = 16'h100c; vf_ok = 1; step();
    lk(1, 16'h2000);
    // R3: load and store to the same address in one cycle
    st_valid = 1; st_pc = 16'h1020; st_addr = 12'd9;
    ld_valid = 1; ld_pc = 16'h2010; ld_addr = 12'd9; step();
    ld(16'h2010, 12'd9);
    // R9: overfill load table; lookups do not refresh
    for (int i = 0; i < 6; i++) begin
      lk(1, 16'h2000);
      ld(16'h2100 + 16'(i * 4), 12'd9);
    end
    for (int i = 0; i < 6; i++) lk(1, 16'h2100 + 16'(i * 4));
    lk(1, 16'h2000);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      st_valid = 1'($urandom % 2); st_pc = 16'h1000 + 16'(($urandom % 6) * 4);
      st_addr = 12'($urandom % 24);
      ld_valid = 1'($urandom % 2); ld_pc = 16'h2000 + 16'(($urandom % 8) * 4);
      ld_addr = 12'($urandom % 24);
      vf_valid = ($urandom % 3) == 0; vf_ok = 1'($urandom % 2);
      vf_ld_pc = 16'h2000 + 16'(($urandom % 8) * 4);
      vf_st_pc = 16'h1000 + 16'(($urandom % 6) * 4);
      lk_valid = 1'($urandom % 2); lk_is_load = 1'($urandom % 2);
      lk_pc = lk_is_load ? 16'h2000 + 16'(($urandom % 8) * 4)
                         : 16'h1000 + 16'(($urandom % 6) * 4);
      step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule